// File: doc/BRIEF.md
# Periodic Byte Sampling Latch

The block takes a stream of 32-bit words, each carrying four bytes, with a qualifier that marks a word as usable. Every usable word is copied into a holding register. The block also keeps a position count through the byte stream, and that count moves forward by the number of bytes in the word, not by clock cycles. Each time the stream crosses another boundary of 100 bytes, the byte that sits exactly on the boundary is copied to an 8-bit output. A one-cycle strobe marks each copy.

The result is a decimated byte stream: one byte out of every hundred. Words without the qualifier are skipped completely, so gaps in the input do not shift the sampling positions. The 8-bit output keeps its last captured value until the next boundary. An active-low reset clears the block.

Top module: `byte_sample_latch`

## Requirements
- R1: A word presented with `valid_i` high appears on `word_o` one clock edge later, and `word_o` keeps that value until the next qualified word.
- R2: The byte position advances by 4 for each qualified word and wraps at 100, so a capture happens on every 25th qualified word after reset.
- R3: Bytes in a word are ordered from bits [7:0] (first) up to bits [31:24] (last). The captured byte is therefore bits [31:24] of the 25th qualified word, and it appears on `byte_o` one clock edge after that word is presented.
- R4: Between captures, `byte_o` holds the last captured byte unchanged.
- R5: `strobe_o` is high for exactly the one cycle after each edge that loads `byte_o`, and it is low at every other time.
- R6: A word with `valid_i` low is ignored. It leaves `word_o` unchanged, it does not advance the byte position, and it cannot cause a capture, even when its data differs from the held values.
- R7: While `rst_ni` is low, `word_o` and `byte_o` are 0x00, `strobe_o` is low, and the byte position is 0. A qualified word presented during reset is discarded, so the next capture comes on the 25th qualified word after reset is released.
- R8: Any number of idle cycles between qualified words leaves the capture positions unchanged. Only the count of qualified words decides which word is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Marks `data_i` as a usable word this cycle |
| data_i | input | 32 | Four-byte input word, first byte in bits [7:0] |
| word_o | output | 32 | Last qualified word that was registered |
| byte_o | output | 8 | Most recently captured boundary byte |
| strobe_o | output | 1 | One-cycle pulse after each new capture |

## Verification
Reset and a capture can fall on the same clock edge. The bench provokes this by holding `rst_ni` low while it presents the 25th qualified word. It then checks three things: no strobe is produced, `byte_o` and `word_o` stay at zero, and the byte position restarts, so the first strobe after release comes exactly on the 25th fresh word. A scoreboard queue holds the bytes that the bench expects to be captured. A monitor compares every strobe against the queue and checks that `byte_o` holds steady in all cycles without a strobe.

// File: rtl/byte_sample_pkg.sv
package byte_sample_pkg;
  localparam int unsigned BYTE_W_DEF      = 8;
  localparam int unsigned WORD_BYTES_DEF  = 4;
  localparam int unsigned PERIOD_DEF      = 100;

  // capture request from counter to capture stage
  typedef struct packed {
    logic       hit;
    logic [7:0] lane;
  } cap_req_t;
endpackage

// File: rtl/word_hold_reg.sv
module word_hold_reg #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (valid_i) word_q <= data_i;
  end

  assign word_o = word_q;

  assert_word_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> word_q == $past(data_i));
  assert_word_ignore_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(word_q));
endmodule

// File: rtl/byte_pos_counter.sv
module byte_pos_counter
  import byte_sample_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned PERIOD     = 100,
  localparam int unsigned CNT_W     = $clog2(PERIOD)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     valid_i,
  output cap_req_t req_o
);
  // PERIOD must be at least WORD_BYTES: one capture per word at most
  logic [CNT_W-1:0] count_q, count_d;
  logic [CNT_W:0]   sum;
  logic [CNT_W:0]   lane_full;
  logic             hit;

  always_comb begin
    sum       = {1'b0, count_q} + (CNT_W+1)'(WORD_BYTES);
    hit       = sum >= (CNT_W+1)'(PERIOD);
    lane_full = (CNT_W+1)'(PERIOD - 1) - {1'b0, count_q};
    count_d   = count_q;
    if (valid_i) count_d = hit ? CNT_W'(sum - (CNT_W+1)'(PERIOD)) : CNT_W'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_d;
  end

  assign req_o.hit  = valid_i && hit;
  assign req_o.lane = 8'(lane_full);

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q < CNT_W'(PERIOD));
  assert_count_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(count_q));
  assert_hit_lane_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o.hit |-> req_o.lane < 8'(WORD_BYTES));
endmodule

// File: rtl/byte_capture.sv
module byte_capture
  import byte_sample_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WORD_BYTES = 4,
  localparam int unsigned WORD_W    = BYTE_W * WORD_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cap_req_t          req_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              strobe_o
);
  logic [BYTE_W-1:0] lanes [WORD_BYTES];
  logic [BYTE_W-1:0] sel;
  logic [BYTE_W-1:0] byte_q;
  logic              strobe_q;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    assign lanes[k] = data_i[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    sel = '0;
    for (int k = 0; k < WORD_BYTES; k++)
      if (req_i.lane == 8'(k)) sel = lanes[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= req_i.hit;
      if (req_i.hit) byte_q <= sel;
    end
  end

  assign byte_o   = byte_q;
  assign strobe_o = strobe_q;

  assert_byte_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i.hit |=> $stable(byte_q));
  assert_strobe_marks_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_q |-> byte_q == $past(byte_q) || !$past(rst_ni));
endmodule

// File: rtl/byte_sample_latch.sv
module byte_sample_latch
  import byte_sample_pkg::*;
#(
  parameter int unsigned BYTE_W     = BYTE_W_DEF,
  parameter int unsigned WORD_BYTES = WORD_BYTES_DEF,
  parameter int unsigned PERIOD     = PERIOD_DEF,
  localparam int unsigned WORD_W    = BYTE_W * WORD_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              strobe_o
);
  cap_req_t req;

  word_hold_reg #(.WORD_W(WORD_W)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .data_i(data_i), .word_o(word_o)
  );

  byte_pos_counter #(.WORD_BYTES(WORD_BYTES), .PERIOD(PERIOD)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .req_o(req)
  );

  byte_capture #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .data_i(data_i),
    .byte_o(byte_o), .strobe_o(strobe_o)
  );

  assert_strobe_needs_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> $past(valid_i));
  assert_strobe_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: tb/byte_sample_latch_test.sv
module byte_sample_latch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] data_i = '0;
  logic [31:0] word_o;
  logic [7:0]  byte_o;
  logic        strobe_o;

  int vectors = 0;
  int miscompares = 0;
  int pos = 0;            // model byte position
  logic [31:0] exp_word = '0;
  logic [7:0]  exp_q[$];
  logic [7:0]  last_byte = '0;
  int pushed = 0;
  int strobes = 0;

  byte_sample_latch uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .word_o(word_o), .byte_o(byte_o), .strobe_o(strobe_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: present one word, update model, push expected capture
  task automatic send(input bit v, input logic [31:0] d);
    @(negedge clk_i);
    valid_i = v;
    data_i  = d;
    if (v) begin
      exp_word = d;
      pos += 4;
      if (pos >= 100) begin
        pos -= 100;
        exp_q.push_back(d[31:24]);  // R3: last lane of boundary word
        pushed++;
      end
    end
    @(posedge clk_i); #1;
    check(word_o == exp_word, v ? "R1" : "R6", word_o, exp_word);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(1'b0, 32'hDEAD_0000 | 32'(i));
  endtask

  // monitor: pops expected captures on strobe, checks hold otherwise
  initial begin
    forever begin
      @(posedge clk_i); #1;
      if (!rst_ni) begin
        last_byte = '0;
        check(byte_o == 8'h00 && !strobe_o && word_o == '0, "R7", {23'd0, strobe_o, byte_o}, 32'h0);
      end else if (strobe_o) begin
        strobes++;
        if (exp_q.size() == 0) check(1'b0, "R5", {24'd0, byte_o}, 32'hFFFF_FFFF);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(byte_o == e, "R3", {24'd0, byte_o}, {24'd0, e});
        end
        last_byte = byte_o;
      end else begin
        check(byte_o == last_byte, "R4", {24'd0, byte_o}, {24'd0, last_byte});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;

    // R2/R3: 50 back-to-back words -> two captures
    for (int i = 0; i < 50; i++) send(1'b1, {8'(i + 8'h40), 8'(i), 8'(i ^ 8'h5A), 8'(~i)});
    idle(2);
    check(strobes == 2, "R2", 32'(strobes), 32'd2);

    // R6/R8: invalid word at boundary slot, idle gaps between words
    for (int i = 0; i < 24; i++) begin
      send(1'b1, {8'(8'h80 + i), 24'h123456});
      if (i % 3 == 0) idle(i % 5 + 1);
    end
    send(1'b0, 32'hEE00_0000);          // would-be 25th word, ignored
    idle(3);
    check(strobes == 2, "R6", 32'(strobes), 32'd2);
    send(1'b1, 32'hC3AA_BB11);          // true 25th word -> capture 0xC3
    idle(2);
    check(strobes == 3, "R8", 32'(strobes), 32'd3);

    // R7: reset on the same edge as the 25th qualified word
    for (int i = 0; i < 24; i++) send(1'b1, {8'(8'h10 + i), 24'hABCDEF});
    @(negedge clk_i);
    valid_i = 1'b1; data_i = 32'h7700_0000; rst_ni = 1'b0;
    pos = 0; exp_word = '0; exp_q.delete();
    @(posedge clk_i); #1;
    check(word_o == '0 && byte_o == 8'h00, "R7", word_o, 32'h0);
    @(negedge clk_i); valid_i = 1'b0; rst_ni = 1'b1;
    for (int i = 0; i < 24; i++) send(1'b1, {8'(8'h20 + i), 24'h0F0F0F});
    idle(2);
    check(strobes == 3, "R7", 32'(strobes), 32'd3);
    send(1'b1, 32'h9911_2233);          // 25th after reset -> 0x99
    idle(3);
    check(strobes == 4 && byte_o == 8'h99, "R7", {24'd0, byte_o}, 32'h99);

    check(exp_q.size() == 0, "R5", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule